// File: doc/BRIEF.md
# Dual-Port Parallel Interface Adapter

This block is a parallel peripheral interface with two 8-bit ports, A and B. Each port has its own direction register, output register and control register, plus two handshake lines: C1 (always an input) and C2 (input or output). A processor reaches the four registers through a two-bit address. The block watches C1 and C2 for a programmed edge and latches an interrupt flag for each line. It drives one active-high interrupt line per port.

Bit 2 of each port's control register chooses which register sits at that port's data address: the direction register or the port data. The two interrupt flags occupy control bits 7 and 6 and cannot be written. The only way to clear them is to read the port data while the port data is selected.

C2 has three modes. It can be an edge-sensing input, a level output that follows a control bit, or a strobe output that idles high. The strobe is triggered by a port A data read or by a port B output write.

The bus is a single-cycle synchronous strobe. Every strobed access is accepted in the cycle it is presented, and there is no back-pressure, so no ready signal exists. Read data is registered and appears on `bus_rdata` in the cycle after the read strobe. All pin inputs are taken to be synchronous to `clk`.

Top module: `dual_port_pia`

## Requirements
- R1: After reset every register and flag is zero. All pins are inputs (`pa_oe`, `pb_oe` = 0), both C2 output enables are 0, and both IRQ outputs are low.
- R2: A write to a control register stores bits 5..0. Bits 7 (C1 flag) and 6 (C2 flag) are read-only, and a control write never changes them.
- R3: Address map: 0 is port A data, 1 is port A control, 2 is port B data, 3 is port B control. With control bit 2 = 0 the data address reads and writes the direction register, which drives the pin output enables.
- R4: With control bit 2 = 1, a data write loads the output register, which drives the port pins. A data read returns the output register bit where the direction bit is 1 and the pin value where it is 0.
- R5: Control bit 1 selects the active C1 edge: 1 means low-to-high, 0 means high-to-low. An active C1 edge sets flag bit 7 whether or not the C1 interrupt is enabled.
- R6: With control bit 5 = 0, C2 is an input. Bit 4 selects its active edge (1 means rising), and an active edge sets flag bit 6.
- R7: A port's IRQ output is high exactly when (bit 7 AND bit 0) OR (bit 6 AND bit 3 AND C2 is an input).
- R8: A data read with control bit 2 = 1 clears both flags of that port. Reading the direction register does not clear them, and nothing else clears them.
- R9: With control bits 5:4 = 11, the C2 output enable is 1 and C2 equals control bit 3.
- R10: Port A strobe mode (bits 5:4 = 10) works as follows:
  - CA2 idles high, and a port A data read with bit 2 = 1 drives it low from the next cycle.
  - With bit 3 = 1 it returns high one cycle later.
  - With bit 3 = 0 it stays low until an active CA1 edge.
- R11: Port B strobe mode (bits 5:4 = 10) works as follows:
  - A write to the port B output register drives CB2 low from the next cycle.
  - With bit 3 = 1 it returns high one cycle later.
  - With bit 3 = 0 it stays low until a port B data read clears a set C1 flag.
- R12: A control register write returns a strobe-mode C2 to its idle high level. Accesses to one port leave the other port's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read strobe |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A output register |
| pa_oe | output | 8 | Port A pin output enables (direction register) |
| ca1 | input | 1 | Port A C1 handshake input |
| ca2_in | input | 1 | Port A C2 input |
| ca2_out | output | 1 | Port A C2 output value |
| ca2_oe | output | 1 | Port A C2 output enable |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B output register |
| pb_oe | output | 8 | Port B pin output enables |
| cb1 | input | 1 | Port B C1 handshake input |
| cb2_in | input | 1 | Port B C2 input |
| cb2_out | output | 1 | Port B C2 output value |
| cb2_oe | output | 1 | Port B C2 output enable |
| irq_a | output | 1 | Port A interrupt, active high |
| irq_b | output | 1 | Port B interrupt, active high |

## Verification
Random direction, output and pin bytes on both ports check the per-bit read mix. A swapped or inverted direction term shows up within a few draws. Directed edges are applied on C1 and C2 in both polarities, with the enable on and off. These separate flag latching from interrupt gating, and show that the unselected edge sets nothing.

Reads of the direction register against reads of port data show whether the clear is tied to the selected register. The strobe sequences cover the fixed one-cycle release and the handshake release on each port. They separate the read-triggered port A strobe from the write-triggered port B strobe.

// File: rtl/pia_pkg.sv
package pia_pkg;
  localparam int PIA_W     = 8;
  localparam int CTL_W     = 6;
  localparam int B_C1_EN   = 0;
  localparam int B_C1_RISE = 1;
  localparam int B_SEL_OUT = 2;
  localparam int B_C2_CTL  = 3;
  localparam int B_C2_MODE = 4;
  localparam int B_C2_DIR  = 5;
  localparam int NPORTS    = 2;
endpackage

// File: rtl/pia_edge_det.sv
module pia_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  input  logic arm,
  output logic hit
);
  logic prev;

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= pin;
  end

  assign hit = arm && (pin != prev) && (pin == rise_sel);
endmodule

// File: rtl/pia_port.sv
module pia_port
  import pia_pkg::*;
#(
  parameter bit WRITE_STROBE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_wr,
  input  logic             ctl_wr,
  input  logic             data_rd,
  input  logic [PIA_W-1:0] wdata,
  input  logic [PIA_W-1:0] pin_in,
  input  logic             c1_in,
  input  logic             c2_in,
  output logic [PIA_W-1:0] data_view,
  output logic [7:0]       ctl_view,
  output logic [PIA_W-1:0] pin_out,
  output logic [PIA_W-1:0] pin_oe,
  output logic             c2_out,
  output logic             c2_oe,
  output logic             irq
);
  logic [PIA_W-1:0] ddr, outr;
  logic [CTL_W-1:0] ctl;
  logic flag1, flag2, strobe_low, strobe_nxt;
  logic c1_hit, c2_hit, rd_clr, strobe_mode, strobe_go, strobe_end;

  pia_edge_det u_c1 (
    .clk(clk), .rst_n(rst_n), .pin(c1_in),
    .rise_sel(ctl[B_C1_RISE]), .arm(1'b1), .hit(c1_hit)
  );

  pia_edge_det u_c2 (
    .clk(clk), .rst_n(rst_n), .pin(c2_in),
    .rise_sel(ctl[B_C2_MODE]), .arm(!ctl[B_C2_DIR]), .hit(c2_hit)
  );

  assign rd_clr      = data_rd && ctl[B_SEL_OUT];
  assign strobe_mode = ctl[B_C2_DIR] && !ctl[B_C2_MODE];

  generate
    if (WRITE_STROBE) begin : g_wr_strobe
      assign strobe_go  = data_wr && ctl[B_SEL_OUT];
      assign strobe_end = ctl[B_C2_CTL] || (rd_clr && flag1);
    end else begin : g_rd_strobe
      assign strobe_go  = rd_clr;
      assign strobe_end = ctl[B_C2_CTL] || c1_hit;
    end
  endgenerate

  always_comb begin
    strobe_nxt = strobe_low;
    if (ctl_wr || !strobe_mode) begin
      strobe_nxt = 1'b0;
    end else begin
      if (strobe_low && strobe_end) strobe_nxt = 1'b0;
      if (strobe_go)                strobe_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ddr        <= '0;
      outr       <= '0;
      ctl        <= '0;
      flag1      <= 1'b0;
      flag2      <= 1'b0;
      strobe_low <= 1'b0;
    end else begin
      if (ctl_wr) ctl <= wdata[CTL_W-1:0];
      if (data_wr) begin
        if (ctl[B_SEL_OUT]) outr <= wdata;
        else                ddr  <= wdata;
      end
      if (c1_hit)      flag1 <= 1'b1;
      else if (rd_clr) flag1 <= 1'b0;
      if (c2_hit)      flag2 <= 1'b1;
      else if (rd_clr) flag2 <= 1'b0;
      strobe_low <= strobe_nxt;
    end
  end

  assign data_view = ctl[B_SEL_OUT] ? ((outr & ddr) | (pin_in & ~ddr)) : ddr;
  assign ctl_view  = {flag1, flag2, ctl};
  assign pin_out   = outr;
  assign pin_oe    = ddr;
  assign c2_oe     = ctl[B_C2_DIR];
  assign c2_out    = ctl[B_C2_DIR] &&
                     (ctl[B_C2_MODE] ? ctl[B_C2_CTL] : !strobe_low);
  assign irq       = (flag1 && ctl[B_C1_EN]) ||
                     (flag2 && ctl[B_C2_CTL] && !ctl[B_C2_DIR]);
endmodule

// File: rtl/dual_port_pia.sv
module dual_port_pia
  import pia_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic [PIA_W-1:0] pa_in,
  output logic [PIA_W-1:0] pa_out,
  output logic [PIA_W-1:0] pa_oe,
  input  logic             ca1,
  input  logic             ca2_in,
  output logic             ca2_out,
  output logic             ca2_oe,
  input  logic [PIA_W-1:0] pb_in,
  output logic [PIA_W-1:0] pb_out,
  output logic [PIA_W-1:0] pb_oe,
  input  logic             cb1,
  input  logic             cb2_in,
  output logic             cb2_out,
  output logic             cb2_oe,
  output logic             irq_a,
  output logic             irq_b
);
  logic [NPORTS-1:0][PIA_W-1:0] pin_in_v, pin_out_v, pin_oe_v, data_v;
  logic [NPORTS-1:0][7:0]       ctl_v;
  logic [NPORTS-1:0]            c1_v, c2_in_v, c2_out_v, c2_oe_v, irq_v;
  logic [7:0]                   ctl_a_view, ctl_b_view;

  assign pin_in_v = {pb_in, pa_in};
  assign c1_v     = {cb1, ca1};
  assign c2_in_v  = {cb2_in, ca2_in};

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    logic hit_port;
    assign hit_port = bus_en && (bus_addr[1] == g[0]);

    pia_port #(.WRITE_STROBE(g == 1)) u_port (
      .clk(clk), .rst_n(rst_n),
      .data_wr(hit_port && bus_we && !bus_addr[0]),
      .ctl_wr(hit_port && bus_we && bus_addr[0]),
      .data_rd(hit_port && !bus_we && !bus_addr[0]),
      .wdata(bus_wdata),
      .pin_in(pin_in_v[g]), .c1_in(c1_v[g]), .c2_in(c2_in_v[g]),
      .data_view(data_v[g]), .ctl_view(ctl_v[g]),
      .pin_out(pin_out_v[g]), .pin_oe(pin_oe_v[g]),
      .c2_out(c2_out_v[g]), .c2_oe(c2_oe_v[g]), .irq(irq_v[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_en && !bus_we)
      bus_rdata <= bus_addr[0] ? ctl_v[bus_addr[1]] : data_v[bus_addr[1]];
  end

  assign pa_out     = pin_out_v[0];
  assign pb_out     = pin_out_v[1];
  assign pa_oe      = pin_oe_v[0];
  assign pb_oe      = pin_oe_v[1];
  assign ca2_out    = c2_out_v[0];
  assign cb2_out    = c2_out_v[1];
  assign ca2_oe     = c2_oe_v[0];
  assign cb2_oe     = c2_oe_v[1];
  assign irq_a      = irq_v[0];
  assign irq_b      = irq_v[1];
  assign ctl_a_view = ctl_v[0];
  assign ctl_b_view = ctl_v[1];
endmodule

// File: rtl/pia_checker.sv
module pia_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_en,
  input logic       bus_we,
  input logic [1:0] bus_addr,
  input logic [7:0] bus_rdata,
  input logic [7:0] pa_oe,
  input logic [7:0] ctl_a,
  input logic [7:0] ctl_b,
  input logic       ca1,
  input logic       cb1,
  input logic       ca2_out,
  input logic       cb2_out,
  input logic       irq_a,
  input logic       irq_b
);
  p_ctlwr_keeps_flags_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == 2'd1) |=>
      ((ctl_a[7:6] & $past(ctl_a[7:6])) == $past(ctl_a[7:6])));

  p_ctlwr_keeps_flags_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == 2'd3) |=>
      ((ctl_b[7:6] & $past(ctl_b[7:6])) == $past(ctl_b[7:6])));

  p_ddr_readback_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr == 2'd0 && !ctl_a[2]) |=>
      (bus_rdata == $past(pa_oe)));

  p_rise_sets_flag_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ca1) && ctl_a[1]) |=> ctl_a[7]);

  p_rise_sets_flag_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cb1) && ctl_b[1]) |=> ctl_b[7]);

  p_irq_quiet_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_a[0] && !(ctl_a[3] && !ctl_a[5])) |-> !irq_a);

  p_irq_quiet_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_b[0] && !(ctl_b[3] && !ctl_b[5])) |-> !irq_b);

  p_flag_clear_by_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_a[7]) |-> $past(bus_en && !bus_we && bus_addr == 2'd0 && ctl_a[2]));

  p_level_out_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_a[5] && ctl_a[4]) |-> (ca2_out == ctl_a[3]));

  p_level_out_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_b[5] && ctl_b[4]) |-> (cb2_out == ctl_b[3]));

  p_read_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr == 2'd0 && ctl_a[5:4] == 2'b10 && ctl_a[2])
      |=> !ca2_out);

  p_write_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == 2'd2 && ctl_b[5:4] == 2'b10 && ctl_b[2])
      |=> !cb2_out);
endmodule

bind dual_port_pia pia_checker u_pia_checker (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .pa_oe(pa_oe),
  .ctl_a(ctl_a_view), .ctl_b(ctl_b_view), .ca1(ca1), .cb1(cb1),
  .ca2_out(ca2_out), .cb2_out(cb2_out), .irq_a(irq_a), .irq_b(irq_b)
);

// File: tb/dual_port_pia_bench.sv
`timescale 1ns/1ps
module dual_port_pia_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, bus_en, bus_we;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic [7:0] pa_in, pa_out, pa_oe, pb_in, pb_out, pb_oe;
  logic ca1, ca2_in, ca2_out, ca2_oe, cb1, cb2_in, cb2_out, cb2_oe, irq_a, irq_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  dual_port_pia u_dual_port_pia (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [7:0] mix(input logic [7:0] o, input logic [7:0] dd,
                                     input logic [7:0] p);
    return (o & dd) | (p & ~dd);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, dd, o, p;
    int unsigned seed;
    seed = $urandom(32'd2024);
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00;
    pa_in = 8'h00; pb_in = 8'h00;
    ca1 = 1'b0; ca2_in = 1'b0; cb1 = 1'b0; cb2_in = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk("R1 pa_oe", pa_oe, 8'h00);
    chk("R1 pb_oe", pb_oe, 8'h00);
    chk("R1 c2 oe/irq", {4'h0, ca2_oe, cb2_oe, irq_a, irq_b}, 8'h00);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk("R1 register", v, 8'h00);
    end

    // R2 read-only flag bits, R9 level output
    wr(2'd1, 8'hFF);
    rd(2'd1, v);
    chk("R2 ctl readback", v, 8'h3F);
    chk("R9 ca2 high", {6'h0, ca2_oe, ca2_out}, 8'h03);
    wr(2'd1, 8'h34);
    chk("R9 ca2 low", {6'h0, ca2_oe, ca2_out}, 8'h02);

    // R3 R4 random direction/output/pin patterns on both ports
    for (int port = 0; port < 2; port++) begin
      for (int it = 0; it < 20; it++) begin
        dd = 8'($urandom); o = 8'($urandom); p = 8'($urandom);
        wr({port[0], 1'b1}, 8'h00);
        wr({port[0], 1'b0}, dd);
        wr({port[0], 1'b1}, 8'h04);
        wr({port[0], 1'b0}, o);
        if (port == 0) pa_in = p; else pb_in = p;
        rd({port[0], 1'b0}, v);
        chk("R4 read mix", v, mix(o, dd, p));
        chk("R4 pin out", port == 0 ? pa_out : pb_out, o);
        chk("R3 pin oe", port == 0 ? pa_oe : pb_oe, dd);
        wr({port[0], 1'b1}, 8'h00);
        rd({port[0], 1'b0}, v);
        chk("R3 ddr readback", v, dd);
      end
    end

    // R5 R7 R8 C1 edges on port A
    wr(2'd1, 8'h07);
    ca1 = 1'b1; idle(1);
    rd(2'd1, v);
    chk("R5 rising flag", v, 8'h87);
    chk("R7 irq_a on", {7'h0, irq_a}, 8'h01);
    rd(2'd0, v);
    rd(2'd1, v);
    chk("R8 read clears", v, 8'h07);
    chk("R7 irq_a off", {7'h0, irq_a}, 8'h00);
    ca1 = 1'b0; idle(1);
    rd(2'd1, v);
    chk("R5 wrong edge ignored", v, 8'h07);
    wr(2'd1, 8'h04);
    ca1 = 1'b1; idle(1);
    ca1 = 1'b0; idle(1);
    rd(2'd1, v);
    chk("R5 falling flag", v, 8'h84);
    chk("R7 disabled irq", {7'h0, irq_a}, 8'h00);
    wr(2'd1, 8'h00);
    rd(2'd1, v);
    chk("R2 write keeps flag", v, 8'h80);
    rd(2'd0, v);
    rd(2'd1, v);
    chk("R8 ddr read keeps flag", v, 8'h80);
    wr(2'd1, 8'h04);
    rd(2'd0, v);
    rd(2'd1, v);
    chk("R8 clear after select", v, 8'h04);

    // R6 C2 input on port B
    wr(2'd3, 8'h1C);
    cb2_in = 1'b1; idle(1);
    rd(2'd3, v);
    chk("R6 c2 rising flag", v, 8'h5C);
    chk("R7 irq_b on", {7'h0, irq_b}, 8'h01);
    rd(2'd2, v);
    cb2_in = 1'b0; idle(1);
    rd(2'd3, v);
    chk("R6 c2 falling ignored", v, 8'h1C);

    // R10 port A read strobe
    wr(2'd1, 8'h2C);
    chk("R10 idle high", {7'h0, ca2_out}, 8'h01);
    rd(2'd0, v);
    chk("R10 strobe low", {7'h0, ca2_out}, 8'h00);
    idle(1);
    chk("R10 one-cycle release", {7'h0, ca2_out}, 8'h01);
    wr(2'd1, 8'h26);
    rd(2'd0, v);
    idle(3);
    chk("R10 held low", {7'h0, ca2_out}, 8'h00);
    ca1 = 1'b1; idle(1);
    chk("R10 c1 release", {7'h0, ca2_out}, 8'h01);
    rd(2'd0, v);
    wr(2'd1, 8'h04);
    chk("R12 ctl write idles strobe", {7'h0, ca2_out}, 8'h00);
    wr(2'd1, 8'h26);
    chk("R12 ctl write idles strobe", {7'h0, ca2_out}, 8'h01);

    // R11 port B write strobe
    wr(2'd3, 8'h2C);
    chk("R11 idle high", {7'h0, cb2_out}, 8'h01);
    wr(2'd2, 8'h55);
    chk("R11 strobe low", {7'h0, cb2_out}, 8'h00);
    idle(1);
    chk("R11 one-cycle release", {7'h0, cb2_out}, 8'h01);
    wr(2'd3, 8'h26);
    wr(2'd2, 8'hAA);
    idle(2);
    chk("R11 held low", {7'h0, cb2_out}, 8'h00);
    cb1 = 1'b1; idle(1);
    chk("R11 edge alone keeps low", {7'h0, cb2_out}, 8'h00);
    rd(2'd2, v);
    chk("R11 read release", {7'h0, cb2_out}, 8'h01);
    rd(2'd3, v);
    chk("R11 flag cleared", v, 8'h26);

    // R12 port isolation
    wr(2'd1, 8'h11);
    rd(2'd3, v);
    chk("R12 port B untouched", v, 8'h26);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule